// File: doc/BRIEF.md
# RGB to BT.656 Formatter

This block sits at the tail of a video output pipeline and feeds a digital television encoder. It accepts a progressive stream of 24-bit RGB pixels and emits an 8-bit byte stream of multiplexed 4:2:2 YCbCr samples. Each line of that stream is framed by embedded timing reference codes and followed by horizontal blanking fill.

Each source pixel is converted to studio-range luma and chroma with fixed-point matrix arithmetic. Chroma is halved horizontally by averaging each pixel pair, and the pair is sent as four bytes. The output is interlaced from the progressive source by keeping every other line, with the kept parity alternating from one source frame to the next. An output field flag travels with every byte.

The source must present exactly `LINE_PIXELS` pixels per line, with at least one idle cycle after every valid pixel. The horizontal-sync flag marks the first pixel of every line. The vertical-sync flag marks the first pixel of every frame and is always raised together with the horizontal-sync flag. Between two lines the source leaves enough idle time for the previous kept line to drain, which is one byte per clock.

Top module: `b656_formatter`

## Requirements
- R1: Luma is Y = 16 + ((66R + 129G + 25B + 128) >>> 8), clamped to the range 16..235.
- R2: For each pixel, Cb = 128 + ((-38R - 74G + 112B + 128) >>> 8) and Cr = 128 + ((112R - 94G - 18B + 128) >>> 8), each clamped to 16..240. The sample sent for a pair is (first + second + 1) >> 1 of the two clamped values.
- R3: Each pixel pair (pixels 2k and 2k+1 of a line) leaves as four bytes in the order Cb, Y of pixel 2k, Cr, Y of pixel 2k+1.
- R4: Every kept line starts with a start code FF 00 00 XY and its active bytes are followed by an end code FF 00 00 XY. XY is, from bit 7 down: 1, F, V, H, V^H, F^H, F^V, F^V^H, with V = 0 on all lines, H = 0 in the start code and H = 1 in the end code.
- R5: After the end code of a kept line, the block emits `BLANK_WORDS` repetitions of the bytes 80 10 80 10.
- R6: The first frame after reset is field F = 0, and F toggles at every vertical-sync. Lines are numbered from 0 at vertical-sync. Field 0 keeps even-numbered lines and field 1 keeps odd-numbered lines.
- R7: A line whose parity does not match the current field produces no output bytes.
- R8: `out_valid` is high exactly when `out_byte` carries a byte of the stream. `out_field` equals the F bit of the line that byte belongs to.
- R9: While reset is asserted, `out_valid` and `out_field` are 0.
- R10: Under the input spacing rule, the internal word queue is never written while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Pixel present on `pix_rgb` |
| pix_rgb | input | 24 | Pixel, R in [23:16], G in [15:8], B in [7:0] |
| pix_hsync | input | 1 | Qualified by `pix_valid`: first pixel of a line |
| pix_vsync | input | 1 | Qualified by `pix_valid`: first pixel of a frame |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Output stream byte |
| out_field | output | 1 | Field bit of the line the current byte belongs to |

## Verification
Two events can fall in the same cycle. The last pixel of a kept line pushes its pair word, and the end-code and blanking words then compete for the queue while the serialiser is still draining earlier words. Sources that place pixels back to back, two cycles apart, force the pair push and the start of the tail into adjacent cycles while the queue holds several entries. The bench compares the exact byte order and field flag against a model computed from R1 to R6, so a stolen, duplicated or misordered word shows up as a miscompare. A frame-start pixel that is also a dropped or kept line start tests the field toggle and the parity decision in the same cycle.

// File: rtl/b656_pkg.sv
// Shared constants and helpers for the BT.656 formatter.
// Assumes 8-bit components and 32-bit words that leave most significant byte first.
package b656_pkg;

    typedef logic [31:0] b656_word_t;

    localparam logic [7:0] LUMA_MIN   = 8'd16;
    localparam logic [7:0] LUMA_MAX   = 8'd235;
    localparam logic [7:0] CHROMA_MIN = 8'd16;
    localparam logic [7:0] CHROMA_MAX = 8'd240;

    localparam b656_word_t BLANK_WORD = 32'h8010_8010;

    // Saturate a signed value into an 8-bit range.
    function automatic logic [7:0] clip8(input int v, input logic [7:0] lo, input logic [7:0] hi);
        if (v < int'(lo)) return lo;
        if (v > int'(hi)) return hi;
        return 8'(v);
    endfunction

    // Build a timing reference word FF 00 00 XY with protection bits.
    function automatic b656_word_t trs_word(input logic f, input logic v, input logic h);
        logic [7:0] xy;
        xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        return {8'hFF, 8'h00, 8'h00, xy};
    endfunction

endpackage

// File: rtl/b656_csc.sv
// Colour space converter: RGB to studio-range YCbCr, one register stage.
// Assumes 8-bit unsigned components; the sync flags pass through aligned with the result.
module b656_csc
    import b656_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [23:0] in_rgb,
    input  logic        in_hs,
    input  logic        in_vs,
    output logic        out_valid,
    output logic        out_hs,
    output logic        out_vs,
    output logic [7:0]  out_y,
    output logic [7:0]  out_cb,
    output logic [7:0]  out_cr
);

    logic [7:0] y_c, cb_c, cr_c;

    // Fixed-point matrix with rounding and clamping.
    always_comb begin
        int r, g, b;
        r = int'(in_rgb[23:16]);
        g = int'(in_rgb[15:8]);
        b = int'(in_rgb[7:0]);
        y_c  = clip8(((66 * r + 129 * g + 25 * b + 128) >>> 8) + 16, LUMA_MIN, LUMA_MAX);
        cb_c = clip8(((-38 * r - 74 * g + 112 * b + 128) >>> 8) + 128, CHROMA_MIN, CHROMA_MAX);
        cr_c = clip8(((112 * r - 94 * g - 18 * b + 128) >>> 8) + 128, CHROMA_MIN, CHROMA_MAX);
    end

    // Register the converted sample and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hs    <= 1'b0;
            out_vs    <= 1'b0;
            out_y     <= LUMA_MIN;
            out_cb    <= 8'd128;
            out_cr    <= 8'd128;
        end else begin
            out_valid <= in_valid;
            out_hs    <= in_valid & in_hs;
            out_vs    <= in_valid & in_vs;
            if (in_valid) begin
                out_y  <= y_c;
                out_cb <= cb_c;
                out_cr <= cr_c;
            end
        end
    end

endmodule

// File: rtl/b656_line_seq.sv
// Line sequencer: decides field and kept lines, pairs samples and emits
// 32-bit words (start code, pixel pairs, end code, blanking fill) to a queue.
// Assumes a full line of LINE_PIXELS samples and that the tail of one kept line
// has been pushed before the next line begins.
module b656_line_seq
    import b656_pkg::*;
#(
    parameter int LINE_PIXELS = 720,
    parameter int BLANK_WORDS = 68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_valid,
    input  logic       s_hs,
    input  logic       s_vs,
    input  logic [7:0] s_y,
    input  logic [7:0] s_cb,
    input  logic [7:0] s_cr,
    input  logic       q_full,
    output logic       push,
    output b656_word_t push_word,
    output logic       push_f
);

    localparam int PW = $clog2(LINE_PIXELS);
    localparam int TW = $clog2(BLANK_WORDS + 2);
    localparam logic [PW-1:0] LAST_PIX   = PW'(LINE_PIXELS - 1);
    localparam logic [TW-1:0] TAIL_START = TW'(BLANK_WORDS + 1);

    logic          f_q, par_q, keep_q;
    logic [PW-1:0] pix_q;
    logic [TW-1:0] tail_q;
    logic [7:0]    y0_q, cb0_q, cr0_q;

    logic          cur_f, cur_par, cur_keep;
    logic [PW-1:0] cur_pix;
    logic          sav_push, pair_push, tail_push;
    logic [8:0]    cb_sum, cr_sum;

    // Field, line parity, keep decision and pixel position of the current sample.
    always_comb begin
        cur_f    = s_vs ? ~f_q : f_q;
        cur_par  = s_vs ? 1'b0 : (s_hs ? ~par_q : par_q);
        cur_keep = s_hs ? (cur_par == cur_f) : keep_q;
        cur_pix  = s_hs ? '0 : pix_q;
    end

    // Push selection: pixel-driven words first, tail words fill idle cycles.
    always_comb begin
        sav_push  = s_valid & cur_keep & s_hs;
        pair_push = s_valid & cur_keep & cur_pix[0];
        tail_push = !sav_push && !pair_push && (tail_q != '0) && !q_full;
        cb_sum    = {1'b0, cb0_q} + {1'b0, s_cb} + 9'd1;
        cr_sum    = {1'b0, cr0_q} + {1'b0, s_cr} + 9'd1;
        push      = sav_push | pair_push | tail_push;
        push_f    = sav_push ? cur_f : f_q;
        if (sav_push)
            push_word = trs_word(cur_f, 1'b0, 1'b0);
        else if (pair_push)
            push_word = {cb_sum[8:1], y0_q, cr_sum[8:1], s_y};
        else if (tail_q == TAIL_START)
            push_word = trs_word(f_q, 1'b0, 1'b1);
        else
            push_word = BLANK_WORD;
    end

    // Track field, parity, keep, pixel count and the held first sample of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= 1'b1;
            par_q  <= 1'b0;
            keep_q <= 1'b0;
            pix_q  <= '0;
            y0_q   <= '0;
            cb0_q  <= '0;
            cr0_q  <= '0;
        end else if (s_valid) begin
            f_q    <= cur_f;
            par_q  <= cur_par;
            keep_q <= cur_keep;
            pix_q  <= cur_pix + 1'b1;
            if (!cur_pix[0]) begin
                y0_q  <= s_y;
                cb0_q <= s_cb;
                cr0_q <= s_cr;
            end
        end
    end

    // Tail counter: end code then blanking words after the last kept pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail_q <= '0;
        else if (s_valid && cur_keep && cur_pix == LAST_PIX)
            tail_q <= TAIL_START;
        else if (tail_push)
            tail_q <= tail_q - 1'b1;
    end

endmodule

// File: rtl/b656_word_fifo.sv
// Small synchronous word queue between the line sequencer and the serialiser.
// Assumes the writer never pushes while full; a pop while empty is ignored.
module b656_word_fifo #(
    parameter int DW    = 33,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);

    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_wr, do_rd;

    assign full    = (cnt_q == (AW + 1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_wr   = wr_en & ~full;
    assign do_rd   = rd_en & ~empty;
    assign rd_data = mem_q[rp_q];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr)
            mem_q[wp_q] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr)
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_rd)
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + (AW + 1)'(do_wr) - (AW + 1)'(do_rd);
        end
    end

endmodule

// File: rtl/b656_formatter.sv
// Top: RGB pixels in, BT.656-style 4:2:2 byte stream out.
// Chain: colour conversion, line sequencer, word queue, byte serialiser.
// Assumes at least one idle cycle after each valid pixel and a line gap long
// enough for the previous kept line to drain.
module b656_formatter
    import b656_pkg::*;
#(
    parameter int LINE_PIXELS = 720,
    parameter int BLANK_WORDS = 68,
    parameter int QUEUE_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_valid,
    input  logic [23:0] pix_rgb,
    input  logic        pix_hsync,
    input  logic        pix_vsync,
    output logic        out_valid,
    output logic [7:0]  out_byte,
    output logic        out_field
);

    logic       csc_valid, csc_hs, csc_vs;
    logic [7:0] csc_y, csc_cb, csc_cr;
    logic       fifo_push, seq_f, fifo_full, fifo_empty, load;
    b656_word_t seq_word, word_q;
    logic [32:0] fifo_out;
    logic       busy_q, fld_q;
    logic [1:0] byte_idx;

    b656_csc u_csc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pix_valid), .in_rgb(pix_rgb), .in_hs(pix_hsync), .in_vs(pix_vsync),
        .out_valid(csc_valid), .out_hs(csc_hs), .out_vs(csc_vs),
        .out_y(csc_y), .out_cb(csc_cb), .out_cr(csc_cr)
    );

    b656_line_seq #(.LINE_PIXELS(LINE_PIXELS), .BLANK_WORDS(BLANK_WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .s_valid(csc_valid), .s_hs(csc_hs), .s_vs(csc_vs),
        .s_y(csc_y), .s_cb(csc_cb), .s_cr(csc_cr),
        .q_full(fifo_full),
        .push(fifo_push), .push_word(seq_word), .push_f(seq_f)
    );

    b656_word_fifo #(.DW(33), .DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fifo_push), .wr_data({seq_f, seq_word}),
        .rd_en(load), .rd_data(fifo_out),
        .full(fifo_full), .empty(fifo_empty)
    );

    assign load = !fifo_empty && (!busy_q || byte_idx == 2'd3);

    // Serialiser state: take a word when idle or on its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            byte_idx <= 2'd0;
            word_q   <= '0;
            fld_q    <= 1'b0;
        end else if (load) begin
            busy_q   <= 1'b1;
            byte_idx <= 2'd0;
            word_q   <= fifo_out[31:0];
            fld_q    <= fifo_out[32];
        end else if (busy_q) begin
            if (byte_idx == 2'd3)
                busy_q <= 1'b0;
            byte_idx <= byte_idx + 2'd1;
        end
    end

    // Byte select, most significant byte first.
    always_comb begin
        case (byte_idx)
            2'd0:    out_byte = word_q[31:24];
            2'd1:    out_byte = word_q[23:16];
            2'd2:    out_byte = word_q[15:8];
            default: out_byte = word_q[7:0];
        endcase
    end

    assign out_valid = busy_q;
    assign out_field = fld_q;

endmodule

// File: rtl/b656_checker.sv
// Property checker for the formatter, attached by bind.
module b656_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic       out_field,
    input logic       fifo_push,
    input logic       fifo_full,
    input logic [1:0] byte_idx,
    input logic       csc_valid,
    input logic [7:0] csc_y,
    input logic [7:0] csc_cb,
    input logic [7:0] csc_cr
);

    // R1: converted luma stays within studio range.
    p_luma_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        csc_valid |-> (csc_y >= 8'd16 && csc_y <= 8'd235));

    // R2: converted chroma stays within studio range.
    p_chroma_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        csc_valid |-> (csc_cb >= 8'd16 && csc_cb <= 8'd240 && csc_cr >= 8'd16 && csc_cr <= 8'd240));

    // R4: an FF byte is the head of a timing code and is followed by 00.
    p_code_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_byte == 8'hFF) |=> (out_valid && out_byte == 8'h00));

    // R8: the field flag does not change inside a word.
    p_field_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && byte_idx != 2'd0) |-> $stable(out_field));

    // R9: output idle in the cycle after a reset edge.
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_field));

    // R10: the word queue is never written while full.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && fifo_full));

endmodule

bind b656_formatter b656_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .out_valid(out_valid), .out_byte(out_byte), .out_field(out_field),
    .fifo_push(fifo_push), .fifo_full(fifo_full), .byte_idx(byte_idx),
    .csc_valid(csc_valid), .csc_y(csc_y), .csc_cb(csc_cb), .csc_cr(csc_cr)
);

// File: tb/tb_b656_formatter.sv
module tb_b656_formatter;

    localparam int W      = 8;
    localparam int HBW    = 2;
    localparam int LINES  = 4;
    localparam int FRAMES = 16;
    localparam int GAP    = 40;
    localparam int NEXP   = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_rgb = '0;
    logic        pix_hsync = 1'b0;
    logic        pix_vsync = 1'b0;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_field;

    int    vectors = 0;
    int    fails = 0;
    int    wr_ptr = 0;
    int    rd_ptr = 0;
    int    cycles = 0;
    bit    done = 0;
    logic [7:0] exp_byte [NEXP];
    logic       exp_f    [NEXP];
    string      exp_tag  [NEXP];

    always #5 clk = ~clk;

    b656_formatter #(.LINE_PIXELS(W), .BLANK_WORDS(HBW), .QUEUE_DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb), .pix_hsync(pix_hsync), .pix_vsync(pix_vsync),
        .out_valid(out_valid), .out_byte(out_byte), .out_field(out_field)
    );

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // R1 reference
    function automatic int ref_y(int r, int g, int b);
        return clampi(((66 * r + 129 * g + 25 * b + 128) >>> 8) + 16, 16, 235);
    endfunction
    // R2 references
    function automatic int ref_cb(int r, int g, int b);
        return clampi(((-38 * r - 74 * g + 112 * b + 128) >>> 8) + 128, 16, 240);
    endfunction
    function automatic int ref_cr(int r, int g, int b);
        return clampi(((112 * r - 94 * g - 18 * b + 128) >>> 8) + 128, 16, 240);
    endfunction

    function automatic int level(int i);
        case (i % 8)
            0: return 0;   1: return 255; 2: return 16;  3: return 235;
            4: return 128; 5: return 64;  6: return 192; default: return 240;
        endcase
    endfunction

    // R4 reference XY byte
    function automatic logic [7:0] ref_xy(logic f, logic h);
        logic v;
        v = 1'b0;
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic expect_byte(input int b, input logic f, input string tag);
        exp_byte[wr_ptr] = 8'(b);
        exp_f[wr_ptr]    = f;
        exp_tag[wr_ptr]  = tag;
        wr_ptr++;
    endtask

    task automatic expect_code(input logic f, input logic h);
        expect_byte(8'hFF, f, "R4");
        expect_byte(8'h00, f, "R4");
        expect_byte(8'h00, f, "R4");
        expect_byte(int'(ref_xy(f, h)), f, "R4");
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Output monitor: compare every byte and its field flag (R3, R4, R5, R8).
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (rd_ptr < wr_ptr) begin
                check(out_byte == exp_byte[rd_ptr], exp_tag[rd_ptr], int'(out_byte), int'(exp_byte[rd_ptr]));
                check(out_field == exp_f[rd_ptr], "R8 field", int'(out_field), int'(exp_f[rd_ptr]));
            end else begin
                check(1'b0, "R7 unexpected byte", int'(out_byte), -1);
            end
            rd_ptr++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int n;
        n = 0;
        // R9: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 valid", int'(out_valid), 0);
        check(out_field == 1'b0, "R9 field", int'(out_field), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 idle", int'(out_valid), 0);

        for (int fr = 0; fr < FRAMES; fr++) begin
            logic f;
            f = logic'(fr % 2); // R6: field toggles per frame, starts at 0
            for (int ln = 0; ln < LINES; ln++) begin
                bit keep;
                int yv0, cb0, cr0;
                keep = ((ln % 2) == (fr % 2)); // R6 parity, R7 drop
                if (keep) expect_code(f, 1'b0);
                yv0 = 0; cb0 = 0; cr0 = 0;
                for (int p = 0; p < W; p++) begin
                    int r, g, b, yv, cb, cr;
                    r = level(n); g = level(n / 8); b = level(n / 64);
                    n++;
                    yv = ref_y(r, g, b); cb = ref_cb(r, g, b); cr = ref_cr(r, g, b);
                    if (keep) begin
                        if (p % 2 == 0) begin
                            yv0 = yv; cb0 = cb; cr0 = cr;
                        end else begin
                            // R3 order, R2 averaging, R1 luma
                            expect_byte((cb0 + cb + 1) >> 1, f, "R2 Cb");
                            expect_byte(yv0, f, "R1 Y0");
                            expect_byte((cr0 + cr + 1) >> 1, f, "R3 Cr");
                            expect_byte(yv, f, "R1 Y1");
                        end
                    end
                    @(negedge clk);
                    pix_valid = 1'b1;
                    pix_rgb   = {8'(r), 8'(g), 8'(b)};
                    pix_hsync = (p == 0);
                    pix_vsync = (p == 0 && ln == 0);
                    @(negedge clk);
                    pix_valid = 1'b0;
                    pix_hsync = 1'b0;
                    pix_vsync = 1'b0;
                end
                if (keep) begin
                    expect_code(f, 1'b1);
                    for (int k = 0; k < HBW; k++) begin
                        expect_byte(8'h80, f, "R5");
                        expect_byte(8'h10, f, "R5");
                        expect_byte(8'h80, f, "R5");
                        expect_byte(8'h10, f, "R5");
                    end
                end
                repeat (GAP) @(negedge clk);
                if (!keep) begin
                    // R7: nothing emitted for the dropped line
                    check(rd_ptr == wr_ptr, "R7 dropped line", rd_ptr, wr_ptr);
                end
            end
        end
        repeat (20) @(negedge clk);
        check(rd_ptr == wr_ptr, "R7 total bytes", rd_ptr, wr_ptr);
        check(out_valid == 1'b0, "R8 idle at end", int'(out_valid), 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule